// File: doc/BRIEF.md
# Single-Move Transfer Control Unit

This block is the sequencing core of a processor whose only operation is a move: every 13-bit instruction copies one byte from a source address to a destination address. There is no opcode. Arithmetic, logic, stack access, memory access and the communication peripheral are reached by reading or writing particular addresses. Control flow comes from one special destination. Writing a byte to it loads the program counter from a branch pointer, but only when that byte is zero.

The unit decodes the instruction word and selects the moved byte. That byte is either the 8-bit source field itself, when the immediate flag is set, or the value at the addressed source. The unit then drives the write strobes of the addressed destination. It owns four pieces of state: the 16-bit program counter, the 16-bit branch pointer, the 24-bit memory pointer and the branch-on-zero decision. Everything else is external and is reached through a source-select/read-enable pair and a destination-select/write-enable pair. Data memory uses dedicated high-byte and low-byte strobes at the memory pointer.

The instruction for the current program counter must be presented combinationally on `instr`. One instruction completes per clock.

Top module: `xfer_core`

## Requirements
- R1: Instruction layout: bit 0 is the immediate flag, bits 4:1 the destination code and bits 12:5 the source field. With the immediate flag at 1, `mv_data` equals the source field; with it at 0, `mv_data` equals the value of the addressed source.
- R2: After reset (`rst_n` low), the program counter, the branch pointer and the memory pointer are all zero.
- R3: When no branch is taken, the program counter advances by one per clock and wraps from 16'hFFFF to 16'h0000.
- R4: Destination code 2 (branch-on-zero) loads the program counter from the branch pointer when `mv_data` is zero. With any other value, the program counter advances normally.
- R5: Destination codes 0 and 1 write the low and high byte of the branch pointer. Source codes 1 and 2 read those bytes back.
- R6: Destination codes 3, 4 and 5 write the low, middle and high byte of the memory pointer. Source codes 5, 6 and 7 read them back, and `mem_addr` always shows the pointer.
- R7: Destination code 6 asserts `mem_wr_hi` and code 7 asserts `mem_wr_lo`. Source code 10 asserts `mem_rd_hi` and code 11 asserts `mem_rd_lo`. For these loads, the moved byte is taken from `src_data`.
- R8: Destination codes 8 to 14 assert `dst_wr_en`, with `dst_sel` carrying the code and `mv_data` the byte. Codes 0 to 7 and 15 leave `dst_wr_en` low.
- R9: Source codes 10 to 40, when not immediate, assert `src_rd_en`, and the moved byte equals `src_data`.
- R10: Source codes 3 and 4 read the low and high byte of the address of the executing instruction. Source codes 8 and 9 read the low and high byte of `stack_ptr`. Source code 0 reads zero.
- R11: Source codes 41 to 255 read as zero and assert no read strobe. Destination code 15 asserts no write strobe and changes no pointer.
- R12: An immediate instruction never asserts `src_rd_en`, `mem_rd_hi` or `mem_rd_lo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 13 | Instruction at the current program counter |
| pc | output | 16 | Program counter (instruction fetch address) |
| src_sel | output | 8 | Source field of the current instruction |
| src_rd_en | output | 1 | Read strobe for an external source |
| src_data | input | 8 | Byte returned by the external source or data memory |
| stack_ptr | input | 16 | Stack address, readable as two bytes |
| dst_sel | output | 4 | Destination code of the current instruction |
| dst_wr_en | output | 1 | Write strobe for an external destination |
| mv_data | output | 8 | Byte being moved this cycle |
| mem_addr | output | 24 | Memory pointer |
| mem_wr_hi | output | 1 | Store high data byte at `mem_addr` |
| mem_wr_lo | output | 1 | Store low data byte at `mem_addr` |
| mem_rd_hi | output | 1 | Load high data byte from `mem_addr` |
| mem_rd_lo | output | 1 | Load low data byte from `mem_addr` |

## Verification
The bench builds the block with its default sizes: a 16-bit program counter, a two-byte branch pointer and a three-byte memory pointer. At these sizes every one of the 256 source codes and all 256 immediate values can be swept, and every one of the 16 destination codes can be walked. The program counter is also driven across its wrap point by branching to 16'hFFFF. Expected bytes come from a bench-side model built from the code tables in the requirements, with the external byte defined as the bitwise complement of `src_sel`.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DW      = 8;
  localparam int INSTR_W = 13;
  localparam int DST_W   = 4;
  localparam int SRC_W   = 8;

  // destination codes
  localparam logic [DST_W-1:0] D_BR_LO  = 4'd0;
  localparam logic [DST_W-1:0] D_BR_HI  = 4'd1;
  localparam logic [DST_W-1:0] D_BRZ    = 4'd2;
  localparam logic [DST_W-1:0] D_MP_LO  = 4'd3;
  localparam logic [DST_W-1:0] D_MP_HI  = 4'd5;
  localparam logic [DST_W-1:0] D_ST_HI  = 4'd6;
  localparam logic [DST_W-1:0] D_ST_LO  = 4'd7;
  localparam logic [DST_W-1:0] D_EXT_LO = 4'd8;
  localparam logic [DST_W-1:0] D_EXT_HI = 4'd14;
  localparam logic [DST_W-1:0] D_NOP    = 4'd15;

  // source codes
  localparam logic [SRC_W-1:0] S_ZERO   = 8'd0;
  localparam logic [SRC_W-1:0] S_BR_LO  = 8'd1;
  localparam logic [SRC_W-1:0] S_BR_HI  = 8'd2;
  localparam logic [SRC_W-1:0] S_PC_LO  = 8'd3;
  localparam logic [SRC_W-1:0] S_PC_HI  = 8'd4;
  localparam logic [SRC_W-1:0] S_MP_LO  = 8'd5;
  localparam logic [SRC_W-1:0] S_MP_MID = 8'd6;
  localparam logic [SRC_W-1:0] S_MP_HI  = 8'd7;
  localparam logic [SRC_W-1:0] S_SP_LO  = 8'd8;
  localparam logic [SRC_W-1:0] S_SP_HI  = 8'd9;
  localparam logic [SRC_W-1:0] S_LD_HI  = 8'd10;
  localparam logic [SRC_W-1:0] S_LD_LO  = 8'd11;
  localparam logic [SRC_W-1:0] S_EXT_HI = 8'd40;

  // bit 0 immediate flag, bits 4:1 destination, bits 12:5 source
  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic             imm;
  } instr_t;

  function automatic logic [DW-1:0] byte_of16(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [15:0] pc_advance(input logic [15:0] cur, input logic take,
                                             input logic [15:0] target);
    return take ? target : cur + 16'd1;
  endfunction
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
#(
  parameter int BR_BYTES = 2,
  parameter int MP_BYTES = 3
) (
  input  logic [INSTR_W-1:0]  instr,
  output logic                imm,
  output logic [DST_W-1:0]    dst,
  output logic [SRC_W-1:0]    src,
  output logic                is_brz,
  output logic [BR_BYTES-1:0] br_wr,
  output logic [MP_BYTES-1:0] mp_wr,
  output logic                st_hi,
  output logic                st_lo,
  output logic                ext_wr
);
  instr_t fields;
  assign fields = instr_t'(instr);
  assign imm    = fields.imm;
  assign dst    = fields.dst;
  assign src    = fields.src;
  assign is_brz = (dst == D_BRZ);
  assign st_hi  = (dst == D_ST_HI);
  assign st_lo  = (dst == D_ST_LO);
  assign ext_wr = (dst >= D_EXT_LO) && (dst <= D_EXT_HI);

  for (genvar b = 0; b < BR_BYTES; b++) begin : g_br_dec
    assign br_wr[b] = (dst == D_BR_LO + DST_W'(b));
  end
  for (genvar m = 0; m < MP_BYTES; m++) begin : g_mp_dec
    assign mp_wr[m] = (dst == D_MP_LO + DST_W'(m));
  end
endmodule

// File: rtl/xfer_ptr_bank.sv
module xfer_ptr_bank #(
  parameter int NBYTES = 2,
  parameter int BW     = 8,
  localparam int TOT_W = NBYTES * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] wr,
  input  logic [BW-1:0]     wdata,
  output logic [TOT_W-1:0]  value
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value[b*BW +: BW] <= '0;
      else if (wr[b]) value[b*BW +: BW] <= wdata;
    end
  end
endmodule

// File: rtl/xfer_src_mux.sv
module xfer_src_mux
  import xfer_pkg::*;
(
  input  logic             imm,
  input  logic [SRC_W-1:0] src,
  input  logic [15:0]      br,
  input  logic [15:0]      pc,
  input  logic [23:0]      mp,
  input  logic [15:0]      sp,
  input  logic [DW-1:0]    ext_data,
  output logic [DW-1:0]    value,
  output logic             ext_rd,
  output logic             ld_hi,
  output logic             ld_lo,
  output logic             undef_src
);
  logic [DW-1:0] sel_val;
  logic          ext_range;

  assign ext_range = (src >= S_LD_HI) && (src <= S_EXT_HI);
  assign ext_rd    = !imm && ext_range;
  assign ld_hi     = !imm && (src == S_LD_HI);
  assign ld_lo     = !imm && (src == S_LD_LO);
  assign undef_src = !imm && (src > S_EXT_HI);

  always_comb begin
    unique case (src)
      S_ZERO:   sel_val = '0;
      S_BR_LO:  sel_val = byte_of16(br, 1'b0);
      S_BR_HI:  sel_val = byte_of16(br, 1'b1);
      S_PC_LO:  sel_val = byte_of16(pc, 1'b0);
      S_PC_HI:  sel_val = byte_of16(pc, 1'b1);
      S_MP_LO:  sel_val = mp[7:0];
      S_MP_MID: sel_val = mp[15:8];
      S_MP_HI:  sel_val = mp[23:16];
      S_SP_LO:  sel_val = byte_of16(sp, 1'b0);
      S_SP_HI:  sel_val = byte_of16(sp, 1'b1);
      default:  sel_val = ext_range ? ext_data : '0;
    endcase
  end

  assign value = imm ? src : sel_val;
endmodule

// File: rtl/xfer_pc.sv
module xfer_pc
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [15:0] target,
  output logic [15:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_advance(pc, take, target);
  end
endmodule

// File: rtl/xfer_core.sv
module xfer_core
  import xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [12:0]         instr,
  output logic [15:0]         pc,
  output logic [7:0]          src_sel,
  output logic                src_rd_en,
  input  logic [7:0]          src_data,
  input  logic [15:0]         stack_ptr,
  output logic [3:0]          dst_sel,
  output logic                dst_wr_en,
  output logic [7:0]          mv_data,
  output logic [23:0]         mem_addr,
  output logic                mem_wr_hi,
  output logic                mem_wr_lo,
  output logic                mem_rd_hi,
  output logic                mem_rd_lo
);
  localparam int BR_BYTES = 2;
  localparam int MP_BYTES = 3;

  logic                imm, is_brz, st_hi, st_lo, ext_wr, undef_src, brz_take;
  logic [DST_W-1:0]    dst;
  logic [SRC_W-1:0]    src;
  logic [BR_BYTES-1:0] br_wr;
  logic [MP_BYTES-1:0] mp_wr;
  logic [15:0]         br;
  logic [23:0]         mp;

  xfer_decode #(.BR_BYTES(BR_BYTES), .MP_BYTES(MP_BYTES)) i_dec (
    .instr(instr), .imm(imm), .dst(dst), .src(src), .is_brz(is_brz),
    .br_wr(br_wr), .mp_wr(mp_wr), .st_hi(st_hi), .st_lo(st_lo), .ext_wr(ext_wr)
  );

  xfer_src_mux i_mux (
    .imm(imm), .src(src), .br(br), .pc(pc), .mp(mp), .sp(stack_ptr),
    .ext_data(src_data), .value(mv_data), .ext_rd(src_rd_en),
    .ld_hi(mem_rd_hi), .ld_lo(mem_rd_lo), .undef_src(undef_src)
  );

  xfer_ptr_bank #(.NBYTES(BR_BYTES), .BW(DW)) i_br (
    .clk(clk), .rst_n(rst_n), .wr(br_wr), .wdata(mv_data), .value(br)
  );

  xfer_ptr_bank #(.NBYTES(MP_BYTES), .BW(DW)) i_mp (
    .clk(clk), .rst_n(rst_n), .wr(mp_wr), .wdata(mv_data), .value(mp)
  );

  assign brz_take = is_brz && (mv_data == '0);

  xfer_pc i_pc (
    .clk(clk), .rst_n(rst_n), .take(brz_take), .target(br), .pc(pc)
  );

  assign src_sel   = src;
  assign dst_sel   = dst;
  assign dst_wr_en = ext_wr;
  assign mem_wr_hi = st_hi;
  assign mem_wr_lo = st_lo;
  assign mem_addr  = mp;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !brz_take |=> pc == $past(pc) + 16'd1); // R3
  AST_BRZ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    brz_take |=> pc == $past(br)); // R4
  AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    imm |-> !src_rd_en && !mem_rd_hi && !mem_rd_lo); // R12
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    undef_src |-> mv_data == 8'd0 && !src_rd_en); // R11
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dst == D_NOP |=> $stable(mem_addr) && $stable(br)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dst_wr_en, mem_wr_hi, mem_wr_lo, is_brz})); // R8
  AST_EXT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |-> mv_data == src_data); // R9
endmodule

// File: tb/test_xfer_core.sv
module test_xfer_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] instr = '0;
  logic [15:0] pc;
  logic [7:0]  src_sel;
  logic        src_rd_en;
  logic [7:0]  src_data;
  logic [15:0] stack_ptr = 16'hBE3F;
  logic [3:0]  dst_sel;
  logic        dst_wr_en;
  logic [7:0]  mv_data;
  logic [23:0] mem_addr;
  logic        mem_wr_hi, mem_wr_lo, mem_rd_hi, mem_rd_lo;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_pc, m_br;
  logic [23:0] m_mp;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign src_data = ~src_sel;

  xfer_core i_xfer_core (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .src_sel(src_sel),
    .src_rd_en(src_rd_en), .src_data(src_data), .stack_ptr(stack_ptr),
    .dst_sel(dst_sel), .dst_wr_en(dst_wr_en), .mv_data(mv_data),
    .mem_addr(mem_addr), .mem_wr_hi(mem_wr_hi), .mem_wr_lo(mem_wr_lo),
    .mem_rd_hi(mem_rd_hi), .mem_rd_lo(mem_rd_lo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_val(input logic im, input logic [7:0] s);
    if (im) return s;
    if (s == 0) return 8'h00;
    if (s == 1) return m_br[7:0];
    if (s == 2) return m_br[15:8];
    if (s == 3) return m_pc[7:0];
    if (s == 4) return m_pc[15:8];
    if (s == 5) return m_mp[7:0];
    if (s == 6) return m_mp[15:8];
    if (s == 7) return m_mp[23:16];
    if (s == 8) return stack_ptr[7:0];
    if (s == 9) return stack_ptr[15:8];
    if (s <= 40) return ~s;
    return 8'h00;
  endfunction

  // execute one instruction: check at negedge, advance model after the edge
  task automatic exec(input logic im, input logic [3:0] d, input logic [7:0] s);
    logic [7:0] v;
    logic ext;
    instr = {s, d, im};
    v = exp_val(im, s);
    ext = !im && s >= 10 && s <= 40;
    @(negedge clk);
    chk("R3 pc", pc, m_pc);
    chk(im ? "R1 imm data" : "R9/R10/R11 src data", mv_data, v);
    chk(im ? "R12 rd strobe" : "R9 rd strobe", src_rd_en, ext);
    chk("R7 load strobes", {mem_rd_hi, mem_rd_lo}, {!im && s == 10, !im && s == 11});
    chk("R8 ext write", {dst_wr_en, dst_sel}, {d >= 8 && d <= 14, d});
    chk("R7 store strobes", {mem_wr_hi, mem_wr_lo}, {d == 6, d == 7});
    chk("R6 mem_addr", mem_addr, m_mp);
    @(posedge clk);
    #1;
    case (d)
      4'd0: m_br[7:0]   = v;
      4'd1: m_br[15:8]  = v;
      4'd3: m_mp[7:0]   = v;
      4'd4: m_mp[15:8]  = v;
      4'd5: m_mp[23:16] = v;
      default: ;
    endcase
    m_pc = (d == 4'd2 && v == 8'h00) ? m_br : m_pc + 16'd1;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none

    m_pc = 0; m_br = 0; m_mp = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 pc reset", pc, 16'h0);
    chk("R2 mp reset", mem_addr, 24'h0);
    rst_n = 1'b1;
    #1;
    exec(1'b0, 4'd15, 8'd1);   // R2 branch pointer low reads zero
    exec(1'b0, 4'd15, 8'd2);

    // R5 branch pointer bytes
    exec(1'b1, 4'd0, 8'h34);
    exec(1'b1, 4'd1, 8'h12);
    exec(1'b0, 4'd15, 8'd1);
    exec(1'b0, 4'd15, 8'd2);
    // R6 memory pointer bytes
    exec(1'b1, 4'd3, 8'hA1);
    exec(1'b1, 4'd4, 8'hB2);
    exec(1'b1, 4'd5, 8'hC3);
    chk("R6 mem_addr full", mem_addr, 24'hC3B2A1);
    // R9 R10 R11: full source sweep
    for (int s = 0; s < 256; s++) exec(1'b0, 4'd15, 8'(s));
    // R1 R12: full immediate sweep
    for (int s = 0; s < 256; s++) exec(1'b1, 4'd15, 8'(s));
    // R7 R8 R11: destination walk with a nonzero byte
    for (int d = 0; d < 16; d++) exec(1'b1, 4'(d), 8'h5C);
    // R8: external write with a register-sourced byte
    exec(1'b0, 4'd9, 8'd20);
    // R4: branch-on-zero
    exec(1'b1, 4'd0, 8'hF0);
    exec(1'b1, 4'd1, 8'h00);
    exec(1'b1, 4'd2, 8'h01);   // not taken
    exec(1'b1, 4'd2, 8'h00);   // taken
    chk("R4 taken target", pc, 16'h00F0);
    exec(1'b0, 4'd2, 8'd0);    // zero source, taken
    exec(1'b0, 4'd2, 8'd30);   // external nonzero, not taken
    exec(1'b0, 4'd2, 8'd99);   // undefined source reads zero, taken
    // R3: wrap
    exec(1'b1, 4'd0, 8'hFF);
    exec(1'b1, 4'd1, 8'hFF);
    exec(1'b1, 4'd2, 8'h00);
    chk("R3 at top", pc, 16'hFFFF);
    exec(1'b0, 4'd15, 8'd3);   // R10 pc low read at top
    chk("R3 wrapped", pc, 16'h0000);
    exec(1'b0, 4'd15, 8'd4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule